// File: doc/BRIEF.md
# Block Transfer DMA Engine

This engine copies a run of data words between one peripheral data port and memory. The CPU does not move the data itself. Software loads a starting memory address and a word count through a small register port. It then writes a control word that selects the direction and the bus-holding policy and sets the start bit. From that point the engine asserts a memory bus request. Whenever it holds the grant and the peripheral is requesting, it moves one word per clock. After each word it steps the address up by one and the remaining count down by one.

Two bus policies are available. In burst mode the request stays high for the whole block. In cycle-stealing mode the request drops for one clock after every word, which gives the bus back to the CPU between words. The system arbiter is expected to favour this request over the CPU. When the count reaches zero, the engine releases the bus and raises an interrupt line. That line stays high until software clears it.

The memory side is a single-cycle port: read data returns in the same clock and writes take effect at the clock edge. The peripheral side is a request/acknowledge pair. One acknowledge marks each word that is moved.

Top module: `dma_block_mover`

## Requirements
- R1: After reset the engine is idle: bus request, acknowledge, both memory strobes and the interrupt are low, and every register reads as zero.
- R2: cfg_sel picks what cfg_rdata shows: 0 returns the address register, 1 the remaining count, and 2 a status word whose bit0 is busy, bit1 is interrupt, bit2 is direction and bit3 is mode. Writes to selectors 0 and 1 load those registers only while idle and are ignored while busy.
- R3: A write to selector 2 with bit0 set, made while idle with a nonzero count, latches bit1 as the direction and bit2 as the mode. Busy and the bus request rise on the next clock. A start written while busy is ignored.
- R4: A word moves, marked by dev_ack, only in a clock where the engine is busy, its request is high, bus_gnt is high and dev_req is high. No word moves otherwise.
- R5: With direction 1 (peripheral to memory) a word asserts mem_we and drives dev_rdata onto mem_wdata. With direction 0 (memory to peripheral) it asserts mem_re and presents mem_rdata on dev_wdata.
- R6: mem_addr carries the address register. Each moved word increments it by one, wrapping at the address width, and decrements the count by one.
- R7: In burst mode (bit2 = 0) the bus request stays high from start until completion.
- R8: In cycle-stealing mode (bit2 = 1) the bus request is low for exactly the one clock that follows each moved word, unless that word completed the block.
- R9: On the clock after the last word, busy clears, the bus request drops and the interrupt rises.
- R10: The interrupt stays high until a write to selector 2 with bit3 set, or a new start. A start given with a count of zero raises the interrupt on the next clock without requesting the bus.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_sel | input | 2 | Register selector |
| cfg_wdata | input | RW | Register write data |
| cfg_rdata | output | RW | Register read data for cfg_sel |
| irq | output | 1 | Block completion interrupt |
| bus_req | output | 1 | Memory bus request |
| bus_gnt | input | 1 | Memory bus grant |
| mem_addr | output | AW | Memory word address |
| mem_re | output | 1 | Memory read strobe |
| mem_we | output | 1 | Memory write strobe |
| mem_wdata | output | DW | Memory write data |
| mem_rdata | input | DW | Memory read data, same cycle |
| dev_req | input | 1 | Peripheral ready to transfer |
| dev_ack | output | 1 | Word moved this cycle |
| dev_rdata | input | DW | Data from the peripheral |
| dev_wdata | output | DW | Data to the peripheral |

## Verification
The bench builds the engine with an 8-bit address, 8-bit count and register port, and 16-bit data. The narrow address lets a block start two words below the top of the address space, so a short transfer crosses the wrap. The grant and the peripheral request follow different short periodic patterns, so grant-without-request and request-without-grant cycles fall both inside and right after the release clocks of cycle-stealing mode. The behavioural model is checked against the design on every clock, together with the final memory and peripheral contents.

// File: rtl/dma_block_mover.sv
module dma_block_mover #(
  parameter int AW = 16,
  parameter int DW = 16,
  parameter int CW = 16,
  parameter int RW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_we,
  input  logic [1:0]    cfg_sel,
  input  logic [RW-1:0] cfg_wdata,
  output logic [RW-1:0] cfg_rdata,
  output logic          irq,
  output logic          bus_req,
  input  logic          bus_gnt,
  output logic [AW-1:0] mem_addr,
  output logic          mem_re,
  output logic          mem_we,
  output logic [DW-1:0] mem_wdata,
  input  logic [DW-1:0] mem_rdata,
  input  logic          dev_req,
  output logic          dev_ack,
  input  logic [DW-1:0] dev_rdata,
  output logic [DW-1:0] dev_wdata
);
  localparam logic [1:0] SEL_ADDR = 2'd0;
  localparam logic [1:0] SEL_CNT  = 2'd1;
  localparam logic [1:0] SEL_CTRL = 2'd2;
  localparam int B_GO    = 0;
  localparam int B_TOMEM = 1;
  localparam int B_STEAL = 2;
  localparam int B_CLR   = 3;

  logic [AW-1:0] addr_q;
  logic [CW-1:0] cnt_q;
  logic busy_q, irq_q, dir_q, steal_q, gap_q;

  wire ctrl_wr = cfg_we && (cfg_sel == SEL_CTRL);
  wire go      = ctrl_wr && cfg_wdata[B_GO] && !busy_q;
  wire move    = busy_q && !gap_q && bus_gnt && dev_req;
  wire last    = move && (cnt_q == CW'(1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      addr_q  <= '0;
      cnt_q   <= '0;
      busy_q  <= 1'b0;
      irq_q   <= 1'b0;
      dir_q   <= 1'b0;
      steal_q <= 1'b0;
      gap_q   <= 1'b0;
    end else begin
      if (cfg_we && !busy_q && cfg_sel == SEL_ADDR) addr_q <= cfg_wdata[AW-1:0];
      if (cfg_we && !busy_q && cfg_sel == SEL_CNT)  cnt_q  <= cfg_wdata[CW-1:0];
      if (ctrl_wr && cfg_wdata[B_CLR]) irq_q <= 1'b0;
      if (go) begin
        dir_q   <= cfg_wdata[B_TOMEM];
        steal_q <= cfg_wdata[B_STEAL];
        busy_q  <= (cnt_q != '0);
        irq_q   <= (cnt_q == '0);
        gap_q   <= 1'b0;
      end else if (move) begin
        addr_q <= addr_q + AW'(1);
        cnt_q  <= cnt_q - CW'(1);
        gap_q  <= steal_q && !last;
        if (last) begin
          busy_q <= 1'b0;
          irq_q  <= 1'b1;
        end
      end else begin
        gap_q <= 1'b0;
      end
    end
  end

  always_comb begin
    case (cfg_sel)
      SEL_ADDR: cfg_rdata = RW'(addr_q);
      SEL_CNT:  cfg_rdata = RW'(cnt_q);
      SEL_CTRL: cfg_rdata = RW'({steal_q, dir_q, irq_q, busy_q});
      default:  cfg_rdata = '0;
    endcase
  end

  assign bus_req   = busy_q && !gap_q;
  assign dev_ack   = move;
  assign mem_we    = move && dir_q;
  assign mem_re    = move && !dir_q;
  assign mem_addr  = addr_q;
  assign mem_wdata = dev_rdata;
  assign dev_wdata = mem_rdata;
  assign irq       = irq_q;
endmodule

module dma_block_mover_chk #(
  parameter int AW = 16,
  parameter int RW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic          cfg_we,
  input logic [1:0]    cfg_sel,
  input logic [RW-1:0] cfg_wdata,
  input logic          irq,
  input logic          bus_req,
  input logic          bus_gnt,
  input logic          dev_req,
  input logic          dev_ack,
  input logic          mem_re,
  input logic          mem_we,
  input logic [AW-1:0] mem_addr,
  input logic          steal_q
);
  AST_ACK_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    dev_ack |-> (bus_gnt && dev_req && bus_req)); // R4
  AST_STROBE_WITH_ACK: assert property (@(posedge clk) disable iff (!rst_n)
    dev_ack |-> (mem_re ^ mem_we)); // R5
  AST_NO_STRAY_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    !dev_ack |-> (!mem_re && !mem_we)); // R5
  AST_ADDR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    dev_ack |=> (mem_addr == $past(mem_addr) + AW'(1))); // R6
  AST_BURST_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_req && !steal_q) |=> (bus_req || irq)); // R7
  AST_STEAL_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    (dev_ack && steal_q) |=> !bus_req); // R8
  AST_DONE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> !bus_req); // R9
  AST_IRQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (irq && !(cfg_we && cfg_sel == 2'd2 && (cfg_wdata[0] || cfg_wdata[3]))) |=> irq); // R10
endmodule

bind dma_block_mover dma_block_mover_chk #(.AW(AW), .RW(RW)) chk_i (
  .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata),
  .irq(irq), .bus_req(bus_req), .bus_gnt(bus_gnt), .dev_req(dev_req), .dev_ack(dev_ack),
  .mem_re(mem_re), .mem_we(mem_we), .mem_addr(mem_addr), .steal_q(steal_q)
);

// File: tb/dma_block_mover_tb.sv
module dma_block_mover_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 8;
  localparam int DW = 16;
  localparam int CW = 8;
  localparam int RW = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cfg_we = 1'b0;
  logic [1:0] cfg_sel = 2'd2;
  logic [RW-1:0] cfg_wdata = '0;
  logic [RW-1:0] cfg_rdata;
  logic irq, bus_req, mem_re, mem_we, dev_ack;
  logic bus_gnt = 1'b0;
  logic dev_req = 1'b0;
  logic [AW-1:0] mem_addr;
  logic [DW-1:0] mem_wdata, mem_rdata, dev_wdata;
  logic [DW-1:0] src_word = 16'h5100;

  logic [DW-1:0] mem_arr [256];
  logic [DW-1:0] sink [$];

  int checks = 0;
  int errors = 0;
  bit done = 0;
  int cyc = 0;
  bit gnt_on = 0, dreq_on = 0;
  int gnt_per = 1, dreq_per = 1;

  int m_addr, m_cnt;
  bit m_busy, m_irq, m_dir, m_steal, m_gap;

  always #(CLK_PERIOD/2) clk = ~clk;

  assign mem_rdata = mem_arr[mem_addr];

  dma_block_mover #(.AW(AW), .DW(DW), .CW(CW), .RW(RW)) dut_i (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata),
    .cfg_rdata(cfg_rdata), .irq(irq), .bus_req(bus_req), .bus_gnt(bus_gnt),
    .mem_addr(mem_addr), .mem_re(mem_re), .mem_we(mem_we), .mem_wdata(mem_wdata),
    .mem_rdata(mem_rdata), .dev_req(dev_req), .dev_ack(dev_ack), .dev_rdata(src_word),
    .dev_wdata(dev_wdata)
  );

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  always @(negedge clk) begin
    cyc++;
    bus_gnt <= gnt_on && ((cyc % gnt_per) != 0);
    dev_req <= dreq_on && ((cyc % dreq_per) != 1);
  end

  // reference model, compared one time unit before each rising edge
  always @(negedge clk) begin
    bit mv;
    int exp_rd;
    #(CLK_PERIOD/2 - 1);
    if (!rst_n) begin
      m_addr = 0; m_cnt = 0; m_busy = 0; m_irq = 0; m_dir = 0; m_steal = 0; m_gap = 0;
    end else begin
      mv = m_busy && !m_gap && bus_gnt && dev_req;
      check(m_steal ? "R8 bus_req" : "R7 bus_req", bus_req, m_busy && !m_gap);
      check("R4 dev_ack", dev_ack, mv);
      check("R5 mem_we", mem_we, mv && m_dir);
      check("R5 mem_re", mem_re, mv && !m_dir);
      if (mv) check("R6 mem_addr", mem_addr, m_addr);
      check("R10 irq", irq, m_irq);
      case (cfg_sel)
        2'd0: exp_rd = m_addr;
        2'd1: exp_rd = m_cnt;
        2'd2: exp_rd = {m_steal, m_dir, m_irq, m_busy};
        default: exp_rd = 0;
      endcase
      check("R2 cfg_rdata", cfg_rdata, exp_rd);
      if (mem_we) mem_arr[mem_addr] = mem_wdata;
      if (dev_ack && !mem_we) sink.push_back(dev_wdata);
      if (dev_ack) src_word = src_word + 16'd1;
      if (cfg_we && !m_busy && cfg_sel == 2'd0) m_addr = cfg_wdata;
      if (cfg_we && !m_busy && cfg_sel == 2'd1) m_cnt = cfg_wdata;
      if (cfg_we && cfg_sel == 2'd2 && cfg_wdata[3]) m_irq = 0;
      if (cfg_we && cfg_sel == 2'd2 && cfg_wdata[0] && !m_busy) begin
        m_dir = cfg_wdata[1]; m_steal = cfg_wdata[2];
        m_busy = (m_cnt != 0); m_irq = (m_cnt == 0); m_gap = 0;
      end else if (mv) begin
        m_addr = (m_addr + 1) % 256;
        m_cnt = m_cnt - 1;
        m_gap = m_steal && (m_cnt != 0);
        if (m_cnt == 0) begin m_busy = 0; m_irq = 1; end
      end else m_gap = 0;
    end
  end

  task automatic wr(input logic [1:0] sel, input logic [RW-1:0] val);
    @(negedge clk);
    cfg_we = 1'b1; cfg_sel = sel; cfg_wdata = val;
    @(negedge clk);
    cfg_we = 1'b0; cfg_sel = 2'd2; cfg_wdata = '0;
  endtask

  task automatic rd(input logic [1:0] sel, output int val);
    @(negedge clk);
    cfg_sel = sel;
    #2 val = cfg_rdata;
    @(negedge clk);
    cfg_sel = 2'd2;
  endtask

  task automatic wait_idle();
    for (int i = 0; i < 400; i++) begin
      @(negedge clk); #2;
      if (cfg_rdata[0] == 1'b0) break;
    end
    check("R9 busy cleared", cfg_rdata[0], 0);
    check("R9 irq raised", irq, 1);
    check("R9 bus released", bus_req, 0);
  endtask

  initial begin
    #(CLK_PERIOD * 20000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    int v, s0;
    for (int i = 0; i < 256; i++) mem_arr[i] = 16'hA000 + 16'(i);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    #2;
    check("R1 bus_req", bus_req, 0);
    check("R1 irq", irq, 0);
    check("R1 dev_ack", dev_ack, 0);
    rd(2'd0, v); check("R1 addr reg", v, 0);
    rd(2'd1, v); check("R1 count reg", v, 0);
    rd(2'd2, v); check("R1 status", v, 0);

    // burst, memory to peripheral, with gaps in grant and request
    gnt_on = 1; gnt_per = 3; dreq_on = 1; dreq_per = 5;
    wr(2'd0, 8'h10); wr(2'd1, 8'd4);
    rd(2'd0, v); check("R2 addr readback", v, 8'h10);
    wr(2'd2, 8'h01);
    #2; check("R3 busy after start", cfg_rdata[0], 1);
    check("R3 bus_req after start", bus_req, 1);
    wr(2'd0, 8'h77);                       // R2 ignored while busy
    wr(2'd2, 8'h07);                       // R3 start ignored while busy
    wait_idle();
    rd(2'd0, v); check("R6 final address", v, 8'h14);
    rd(2'd1, v); check("R6 final count", v, 0);
    rd(2'd2, v); check("R3 mode/dir kept", v & 12, 0);
    check("R5 words to peripheral", sink.size(), 4);
    for (int k = 0; k < 4 && k < sink.size(); k++) check("R5 peripheral data", sink[k], 16'hA010 + k);
    #20;
    check("R10 irq held", irq, 1);
    wr(2'd2, 8'h08);
    #2; check("R10 irq cleared", irq, 0);

    // cycle stealing, peripheral to memory
    dreq_per = 4; gnt_per = 7;
    s0 = src_word;
    wr(2'd0, 8'h40); wr(2'd1, 8'd5); wr(2'd2, 8'h07);
    wait_idle();
    for (int k = 0; k < 5; k++) check("R5 memory written", mem_arr[8'h40 + k], s0 + k);
    check("R6 next word untouched", mem_arr[8'h45], 16'hA045);
    rd(2'd2, v); check("R2 status dir/mode", v, 4'hE);

    // address wrap, burst, constant grant
    gnt_per = 1000; dreq_per = 1000;
    sink.delete();
    wr(2'd0, 8'hFE); wr(2'd1, 8'd3); wr(2'd2, 8'h01);
    wait_idle();
    check("R6 wrap count", sink.size(), 3);
    if (sink.size() == 3) begin
      check("R6 wrap word0", sink[0], 16'hA0FE);
      check("R6 wrap word1", sink[1], 16'hA0FF);
      check("R6 wrap word2", sink[2], 16'hA000);
    end
    rd(2'd0, v); check("R6 wrapped address", v, 8'h01);

    // zero count start
    wr(2'd2, 8'h08);
    wr(2'd1, 8'd0); wr(2'd2, 8'h01);
    #2; check("R10 zero count irq", irq, 1);
    check("R10 zero count no request", bus_req, 0);
    check("R10 zero count not busy", cfg_rdata[0], 0);
    repeat (5) @(negedge clk);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule